// File: doc/BRIEF.md
# Serial Control Register Loader

This block takes configuration frames from a single serial line and turns them into a set of decoded control fields for a mixed-signal front end. The line is sampled once per falling edge of a word strobe. The line rests high. A low bit opens a frame. Fifteen more bits follow: a 12-bit payload sent most significant bit first, then a 3-bit register selector, also sent most significant bit first.

A frame is written only once at least sixteen high bits in a row have followed it. A low bit that comes in that stop window throws the frame away. Six live registers, selected by 0 to 5, hold the payloads. Selectors 6 and 7 change nothing. The registers feed the decoded outputs: receive gain, external gain pins, transmit attenuation, general-purpose pins, the sign-format flag, the loopback and enable flags, the word-clock divider, an oscillator DAC word, the interface edge choices and one spare register.

Writing register 2 with payload bit 3 at zero sends a one-cycle clear pulse to the saturation logic. Every other function keeps running while a frame is coming in.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset every decoded output is zero and `clip_clr` is low.
- R2: Only a falling edge of `wstrb` samples `ser_in`. The frame format is a start bit (0), then payload bits 11 down to 0, then selector bits 2 down to 0. Changes on `ser_in` with no strobe fall are never sampled.
- R3: A frame takes effect only after the 16th consecutive high stop bit has been sampled. After 15 high bits the outputs are unchanged.
- R4: A low bit sampled before 16 stop bits have been counted discards the pending frame. The receiver looks for a new start bit only after a later run of 16 high bits.
- R5: A frame addressed to selector 6 or 7 changes no output and produces no clear pulse.
- R6: Selector 0: `rx_gain` = payload[5:0], `ext_gain` = payload[7:6].
- R7: Selector 1: `tx_atten` = payload[4:0], `gpo` = payload[7:5], `one_sign_fmt` = payload[8].
- R8: Selector 2: `dig_loop` = payload[0], `ana_loop` = payload[1], `rx_enable` = payload[2], `word_div` = payload[5:4].
- R9: Selector 3: `osc_dac` = payload[9:0].
- R10: Selector 4: `tx_rise_edge` = payload[0], `rx_rise_edge` = payload[1], `rx2tx_loop` = payload[2]. Selector 5: `spare_cfg` = payload[11:0].
- R11: `clip_clr` is high for exactly one clock each time a selector-2 frame is committed with payload[3] = 0, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wstrb | input | 1 | Word strobe; its falling edge samples the serial line |
| ser_in | input | 1 | Serial configuration line, idles high |
| rx_gain | output | 6 | Receive gain code |
| ext_gain | output | 2 | External gain control pins |
| tx_atten | output | 5 | Transmit attenuation, 1 dB per step |
| gpo | output | 3 | General-purpose outputs |
| one_sign_fmt | output | 1 | 1 = one sign bit sample format, 0 = two |
| dig_loop | output | 1 | Digital loopback, transmit into receive |
| ana_loop | output | 1 | Analog loopback |
| rx_enable | output | 1 | Receive path enable |
| word_div | output | 2 | Word-clock divider select |
| clip_clr | output | 1 | One-cycle clear pulse for the saturation flag |
| osc_dac | output | 10 | Oscillator tuning DAC word |
| tx_rise_edge | output | 1 | Transmit nibbles captured on rising edge |
| rx_rise_edge | output | 1 | Receive nibbles captured on rising edge |
| rx2tx_loop | output | 1 | Digital loopback, receive into transmit |
| spare_cfg | output | 12 | Contents of register 5 |

## Verification
If the bit counter is misaligned, payload and selector bits land in the wrong fields. A wrong pattern then appears in a different field group, two clocks after the commit strobe edge. If the stop counter or the pending flag is wrong, a frame is committed too early, too late, or after it was aborted. Comparing outputs around the 15th and 16th stop bits catches this within one strobe period. A bad selector decode shows up as a change in a group that should not move, or as a missing or extra clear pulse.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;

    typedef enum logic [1:0] {
        RX_HUNT  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_STOP  = 2'd2
    } rx_state_e;

    // register selectors
    localparam int SEL_RX   = 0;
    localparam int SEL_TX   = 1;
    localparam int SEL_CTL  = 2;
    localparam int SEL_DAC  = 3;
    localparam int SEL_IFC  = 4;
    localparam int SEL_AUX  = 5;

    // control register bit that keeps the saturation flag (0 = clear it)
    localparam int CLIP_KEEP_BIT = 3;

endpackage

// File: rtl/cfg_strobe_edge.sv
`timescale 1ns/1ps
module cfg_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic wstrb,
    input  logic ser_in,
    output logic bit_valid,
    output logic bit_val
);
    logic strb_d, strb_q;

    always_comb begin
        strb_d    = wstrb;
        bit_valid = strb_q & ~wstrb;
        bit_val   = ser_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strb_q <= 1'b0;
        else        strb_q <= strb_d;
    end
endmodule

// File: rtl/cfg_frame_rx.sv
`timescale 1ns/1ps
module cfg_frame_rx
    import cfg_loader_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int ID_W     = 3,
    parameter int STOP_MIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_val,
    output logic              wr_en,
    output logic [ID_W-1:0]   wr_id,
    output logic [DATA_W-1:0] wr_data
);
    localparam int FRAME_W    = DATA_W + ID_W;
    localparam int BIT_CNT_W  = $clog2(FRAME_W + 1);
    localparam int STOP_CNT_W = $clog2(STOP_MIN + 1);

    typedef struct packed {
        rx_state_e              state;
        logic [FRAME_W-1:0]     shift;
        logic [BIT_CNT_W-1:0]   bit_cnt;
        logic [STOP_CNT_W-1:0]  stop_cnt;
        logic                   pending;
        logic                   wr;
    } rx_t;

    rx_t d, q;

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        if (bit_valid) begin
            unique case (q.state)
                RX_HUNT: begin
                    if (!bit_val) begin
                        d.state   = RX_SHIFT;
                        d.bit_cnt = '0;
                    end
                end
                RX_SHIFT: begin
                    d.shift = {q.shift[FRAME_W-2:0], bit_val};
                    if (q.bit_cnt == BIT_CNT_W'(FRAME_W - 1)) begin
                        d.state    = RX_STOP;
                        d.stop_cnt = '0;
                        d.pending  = 1'b1;
                    end else begin
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (!bit_val) begin
                        // early low: drop the frame, count the stop run again
                        d.pending  = 1'b0;
                        d.stop_cnt = '0;
                    end else if (q.stop_cnt == STOP_CNT_W'(STOP_MIN - 1)) begin
                        d.wr       = q.pending;
                        d.pending  = 1'b0;
                        d.stop_cnt = '0;
                        d.state    = RX_HUNT;
                    end else begin
                        d.stop_cnt = q.stop_cnt + 1'b1;
                    end
                end
                default: d.state = RX_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: RX_HUNT, default: '0};
        else        q <= d;
    end

    assign wr_en   = q.wr;
    assign wr_id   = q.shift[ID_W-1:0];
    assign wr_data = q.shift[FRAME_W-1:ID_W];
endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
module cfg_reg_bank #(
    parameter int DATA_W   = 12,
    parameter int ID_W     = 3,
    parameter int NUM_REGS = 6,
    parameter int CLIP_REG = 2,
    parameter int CLIP_BIT = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ID_W-1:0]                  wr_id,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
    output logic                             clip_clr
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic                            clip;
    } bank_t;

    bank_t d, q;
    logic [NUM_REGS-1:0] wsel;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign wsel[i] = wr_en && (wr_id == ID_W'(i));
    end

    always_comb begin
        d      = q;
        d.clip = wsel[CLIP_REG] && !wr_data[CLIP_BIT];
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wsel[i]) d.regs[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign regs     = q.regs;
    assign clip_clr = q.clip;
endmodule

// File: rtl/serial_cfg_loader.sv
`timescale 1ns/1ps
module serial_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int ID_W     = 3,
    parameter int STOP_MIN = 16,
    parameter int NUM_REGS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wstrb,
    input  logic        ser_in,
    output logic [5:0]  rx_gain,
    output logic [1:0]  ext_gain,
    output logic [4:0]  tx_atten,
    output logic [2:0]  gpo,
    output logic        one_sign_fmt,
    output logic        dig_loop,
    output logic        ana_loop,
    output logic        rx_enable,
    output logic [1:0]  word_div,
    output logic        clip_clr,
    output logic [9:0]  osc_dac,
    output logic        tx_rise_edge,
    output logic        rx_rise_edge,
    output logic        rx2tx_loop,
    output logic [11:0] spare_cfg
);
    logic                            bit_valid;
    logic                            bit_val;
    logic                            wr_en;
    logic [ID_W-1:0]                 wr_id;
    logic [DATA_W-1:0]               wr_data;
    logic [NUM_REGS-1:0][DATA_W-1:0] cfg_regs;

    cfg_strobe_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .wstrb     (wstrb),
        .ser_in    (ser_in),
        .bit_valid (bit_valid),
        .bit_val   (bit_val)
    );

    cfg_frame_rx #(
        .DATA_W   (DATA_W),
        .ID_W     (ID_W),
        .STOP_MIN (STOP_MIN)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_val   (bit_val),
        .wr_en     (wr_en),
        .wr_id     (wr_id),
        .wr_data   (wr_data)
    );

    cfg_reg_bank #(
        .DATA_W   (DATA_W),
        .ID_W     (ID_W),
        .NUM_REGS (NUM_REGS),
        .CLIP_REG (SEL_CTL),
        .CLIP_BIT (CLIP_KEEP_BIT)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_id    (wr_id),
        .wr_data  (wr_data),
        .regs     (cfg_regs),
        .clip_clr (clip_clr)
    );

    // field decode
    assign rx_gain      = cfg_regs[SEL_RX][5:0];
    assign ext_gain     = cfg_regs[SEL_RX][7:6];
    assign tx_atten     = cfg_regs[SEL_TX][4:0];
    assign gpo          = cfg_regs[SEL_TX][7:5];
    assign one_sign_fmt = cfg_regs[SEL_TX][8];
    assign dig_loop     = cfg_regs[SEL_CTL][0];
    assign ana_loop     = cfg_regs[SEL_CTL][1];
    assign rx_enable    = cfg_regs[SEL_CTL][2];
    assign word_div     = cfg_regs[SEL_CTL][5:4];
    assign osc_dac      = cfg_regs[SEL_DAC][9:0];
    assign tx_rise_edge = cfg_regs[SEL_IFC][0];
    assign rx_rise_edge = cfg_regs[SEL_IFC][1];
    assign rx2tx_loop   = cfg_regs[SEL_IFC][2];
    assign spare_cfg    = cfg_regs[SEL_AUX];
endmodule

// File: rtl/serial_cfg_loader_chk.sv
`timescale 1ns/1ps
module serial_cfg_loader_chk #(
    parameter int DATA_W   = 12,
    parameter int ID_W     = 3,
    parameter int NUM_REGS = 6
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bit_valid,
    input logic                         wr_en,
    input logic [ID_W-1:0]              wr_id,
    input logic [DATA_W-1:0]            wr_data,
    input logic [NUM_REGS*DATA_W-1:0]   cfg_all,
    input logic [9:0]                   osc_dac,
    input logic                         clip_clr
);
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_all == '0 && !clip_clr));  // R1

    AST_WRITE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(bit_valid));  // R2

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_all));  // R3

    AST_RSVD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_id >= ID_W'(NUM_REGS)) |=> ($stable(cfg_all) && !clip_clr));  // R5

    AST_DAC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_id == ID_W'(3)) |=> (osc_dac == $past(wr_data[9:0])));  // R9

    AST_SPARE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_id == ID_W'(5)) |=> (cfg_all[NUM_REGS*DATA_W-1 -: DATA_W] == $past(wr_data)));  // R10

    AST_CLIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        clip_clr |=> !clip_clr);  // R11

    AST_CLIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        clip_clr |-> $past(wr_en && wr_id == ID_W'(2) && !wr_data[3]));  // R11
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(
    .DATA_W   (DATA_W),
    .ID_W     (ID_W),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .wr_en     (wr_en),
    .wr_id     (wr_id),
    .wr_data   (wr_data),
    .cfg_all   (cfg_regs),
    .osc_dac   (osc_dac),
    .clip_clr  (clip_clr)
);

// File: tb/tb_serial_cfg_loader.sv
`timescale 1ns/1ps
module tb_serial_cfg_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wstrb = 1'b0;
    logic        ser_in = 1'b1;
    logic [5:0]  rx_gain;
    logic [1:0]  ext_gain;
    logic [4:0]  tx_atten;
    logic [2:0]  gpo;
    logic        one_sign_fmt, dig_loop, ana_loop, rx_enable;
    logic [1:0]  word_div;
    logic        clip_clr;
    logic [9:0]  osc_dac;
    logic        tx_rise_edge, rx_rise_edge, rx2tx_loop;
    logic [11:0] spare_cfg;

    int checks = 0;
    int failures = 0;
    int clip_count = 0;

    always #4 clk = ~clk;

    serial_cfg_loader dut (
        .clk(clk), .rst_n(rst_n), .wstrb(wstrb), .ser_in(ser_in),
        .rx_gain(rx_gain), .ext_gain(ext_gain), .tx_atten(tx_atten), .gpo(gpo),
        .one_sign_fmt(one_sign_fmt), .dig_loop(dig_loop), .ana_loop(ana_loop),
        .rx_enable(rx_enable), .word_div(word_div), .clip_clr(clip_clr),
        .osc_dac(osc_dac), .tx_rise_edge(tx_rise_edge), .rx_rise_edge(rx_rise_edge),
        .rx2tx_loop(rx2tx_loop), .spare_cfg(spare_cfg)
    );

    always @(posedge clk) if (rst_n && clip_clr) clip_count++;

    typedef struct packed {
        logic [2:0]  id;
        logic [11:0] pay;
        logic [11:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 12'hFFF, 12'h0FF},
        '{3'd0, 12'h0A5, 12'h0A5},
        '{3'd1, 12'h1F3, 12'h1F3},
        '{3'd1, 12'hE40, 12'h040},
        '{3'd2, 12'hFFF, 12'h037},
        '{3'd2, 12'h012, 12'h012},
        '{3'd3, 12'hFFF, 12'h3FF},
        '{3'd3, 12'h155, 12'h155},
        '{3'd3, 12'hC00, 12'h000},
        '{3'd4, 12'hFFD, 12'h005},
        '{3'd4, 12'h002, 12'h002},
        '{3'd5, 12'hA5C, 12'hA5C}
    };

    // field groups seen at the ports, laid out as the payload bits (R6..R10)
    function automatic logic [11:0] view(input int id);
        case (id)
            0: return {4'b0, ext_gain, rx_gain};
            1: return {3'b0, one_sign_fmt, gpo, tx_atten};
            2: return {6'b0, word_div, 1'b0, rx_enable, ana_loop, dig_loop};
            3: return {2'b0, osc_dac};
            4: return {9'b0, rx2tx_loop, rx_rise_edge, tx_rise_edge};
            default: return spare_cfg;
        endcase
    endfunction

    function automatic string req_of(input int id);
        case (id)
            0: return "R6";
            1: return "R7";
            2: return "R8";
            3: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk);
        ser_in = b;
        wstrb  = 1'b1;
        repeat (2) @(negedge clk);
        wstrb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_body(input logic [2:0] id, input logic [11:0] pay);
        put_bit(1'b0);
        for (int i = 11; i >= 0; i--) put_bit(pay[i]);
        for (int i = 2; i >= 0; i--) put_bit(id[i]);
    endtask

    task automatic send_frame(input logic [2:0] id, input logic [11:0] pay);
        send_body(id, pay);
        for (int i = 0; i < 16; i++) put_bit(1'b1);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [11:0] snap [6];
        int clip_snap;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 6; i++) check("R1", view(i), 12'h000);
        check("R1", {11'b0, clip_clr}, 12'h000);

        // table of frames
        for (int v = 0; v < NV; v++) begin
            send_frame(VECS[v].id, VECS[v].pay);
            check(req_of(int'(VECS[v].id)), view(int'(VECS[v].id)), VECS[v].exp);
        end

        // R11: one clear from the table (0x012 has bit 3 = 0)
        check("R11", 12'(clip_count), 12'd1);
        send_frame(3'd2, 12'h008);
        check("R11", 12'(clip_count), 12'd1);
        check("R8", view(2), 12'h000);
        send_frame(3'd2, 12'h000);
        check("R11", 12'(clip_count), 12'd2);

        // R5: reserved selectors
        for (int i = 0; i < 6; i++) snap[i] = view(i);
        clip_snap = clip_count;
        send_frame(3'd6, 12'h000);
        send_frame(3'd7, 12'hFFF);
        for (int i = 0; i < 6; i++) check("R5", view(i), snap[i]);
        check("R5", 12'(clip_count), 12'(clip_snap));

        // R3: 15 stop bits are not enough, the 16th commits
        send_body(3'd3, 12'h2AA);
        for (int i = 0; i < 15; i++) put_bit(1'b1);
        repeat (2) @(negedge clk);
        check("R3", view(3), 12'h000);
        put_bit(1'b1);
        repeat (2) @(negedge clk);
        check("R3", view(3), 12'h2AA);

        // R4: early low in stop window drops the frame
        send_body(3'd3, 12'h0F0);
        for (int i = 0; i < 10; i++) put_bit(1'b1);
        put_bit(1'b0);
        for (int i = 0; i < 16; i++) put_bit(1'b1);
        repeat (2) @(negedge clk);
        check("R4", view(3), 12'h2AA);
        send_frame(3'd3, 12'h111);
        check("R4", view(3), 12'h111);

        // R2: line activity without a strobe fall is not sampled
        @(negedge clk);
        wstrb = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ser_in = i[0];
        end
        ser_in = 1'b1;
        send_frame(3'd5, 12'h3C3);
        check("R2", view(5), 12'h3C3);
        @(negedge clk);
        wstrb = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ser_in = ~i[0];
        end
        ser_in = 1'b1;
        send_frame(3'd0, 12'h0C7);
        check("R2", view(0), 12'h0C7);
        check("R2", view(5), 12'h3C3);

        finish_run();
    end
endmodule